// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a synchronous user port and an external asynchronous static RAM. It takes one single-word read or write request at a time through a request/ready handshake. It then drives the memory's select, output-enable, write-enable, address and data pins in a sequence whose every interval meets the memory's access, pulse, setup and bus-release limits. Each limit is given in nanoseconds as a parameter and is converted at elaboration to whole clock cycles, rounded up. Read results return on the user side with a one-cycle valid strobe.

The memory is selected through two enables, one active-low and one active-high, which the controller always moves together. In the normal mode, output enable is asserted only while a read is in progress. In the write-enable-only mode, output enable stays asserted from the first cycle after reset, and writes and reads differ only in the write-enable line. The controller then waits out the memory's output release after write enable falls before it turns on its own data driver. The data bus is presented as separate output, output-enable and input pins; the pad that joins them lies outside the block.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, both chip enables are inactive (`sram_cs_n`=1, `sram_cs`=0), `sram_oe_n`=1, `sram_we_n`=1, `sram_dq_oe`=0, `ready`=1 and `rd_valid`=0.
- R2: The memory is selected only when `sram_cs_n`=0 and `sram_cs`=1, and the two enables always change together. A read keeps the memory selected for RD cycles, and a write keeps it selected for 1+W cycles. Here RD = max(ceil(T_AA/CLK_NS), ceil(T_ACE/CLK_NS), 1).
- R3: A read holds the address and selection for RD cycles and captures `sram_dq_in` on the last of them. `rd_valid` is then high for exactly one cycle, in the RD+1-th cycle after the accepting clock edge, with the captured word on `rd_data`.
- R4: After a read, the memory stays deselected for FL = max(ceil(T_HZOE/CLK_NS), ceil(T_HZCE/CLK_NS)) cycles before `ready` returns. `ready` is first high in cycle RD+FL+1 after acceptance.
- R5: A write has one selected setup cycle with `sram_we_n` high, then `sram_we_n` low for W cycles, where W = max(ceil(T_PWE), ceil(T_AW), ceil(T_HZWE)+max(ceil(T_SD),1), ceil(T_WC)-1, 1), each in cycles. `ready` is first high in cycle W+HD+2 after acceptance, where HD = ceil(T_HD/CLK_NS).
- R6: The data driver (`sram_dq_oe`) turns on only after ceil(T_HZWE/CLK_NS) cycles of write enable low. It stays on until write enable rises, plus HD cycles, so it is on for W-ceil(T_HZWE)+HD cycles per write. It is never on while the memory may still drive the bus.
- R7: While write enable is low, `sram_addr` and `sram_dq_out` are stable. Write data is driven for at least ceil(T_SD/CLK_NS) cycles and the address for at least ceil(T_AW/CLK_NS) cycles before write enable rises.
- R8: A request is accepted only on a clock edge where `req` and `ready` are both 1. Acceptance drops `ready` on the next cycle, and a request raised while `ready` is 0 has no effect.
- R9: With WE_ONLY=1, `sram_oe_n` is 0 in every cycle from the first cycle after reset. With WE_ONLY=0, `sram_oe_n` is 0 only during the RD cycles of a read and never at the same time as `sram_we_n`=0.
- R10: A read returns the word most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request word address |
| req_wdata | input | DATA_W | Request write data |
| ready | output | 1 | Controller idle, request will be accepted |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | DATA_W | Read result |
| sram_cs_n | output | 1 | Low-active chip enable |
| sram_cs | output | 1 | High-active chip enable |
| sram_oe_n | output | 1 | Low-active output enable |
| sram_we_n | output | 1 | Low-active write enable |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the controller's data driver |
| sram_dq_in | input | DATA_W | Data from the memory |

## Verification
On every cycle, the assertions check that the two chip enables move together and that write enable falls only while the memory is selected. They also check that the data driver is never on while the memory is selected with write enable high, that address and write data hold still through a write pulse, and that the read strobe lasts one cycle. In addition, they check that acceptance always drops ready and that output enable behaves as the chosen mode requires. Only the bench scenarios can show the interval lengths: read latency, write pulse width, driver-on span and turnaround. The same holds for the absence of contention against a memory model that keeps driving for its release time, and for data returned correctly across random mixes of reads and writes in both modes.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter bit WE_ONLY = 1'b0,
  parameter int T_AA    = 20,
  parameter int T_ACE   = 20,
  parameter int T_HZOE  = 8,
  parameter int T_HZCE  = 10,
  parameter int T_WC    = 20,
  parameter int T_PWE   = 13,
  parameter int T_SD    = 10,
  parameter int T_AW    = 15,
  parameter int T_HZWE  = 10,
  parameter int T_HD    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_cs_n,
  output logic              sram_cs,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int C_AA   = (T_AA   + CLK_NS - 1) / CLK_NS;
  localparam int C_ACE  = (T_ACE  + CLK_NS - 1) / CLK_NS;
  localparam int C_HZOE = (T_HZOE + CLK_NS - 1) / CLK_NS;
  localparam int C_HZCE = (T_HZCE + CLK_NS - 1) / CLK_NS;
  localparam int C_WC   = (T_WC   + CLK_NS - 1) / CLK_NS;
  localparam int C_PWE  = (T_PWE  + CLK_NS - 1) / CLK_NS;
  localparam int C_SD   = (T_SD   + CLK_NS - 1) / CLK_NS;
  localparam int C_AW   = (T_AW   + CLK_NS - 1) / CLK_NS;
  localparam int C_HZWE = (T_HZWE + CLK_NS - 1) / CLK_NS;
  localparam int C_HD   = (T_HD   + CLK_NS - 1) / CLK_NS;

  localparam int RD0 = (C_AA > C_ACE) ? C_AA : C_ACE;
  localparam int RD  = (RD0 > 1) ? RD0 : 1;
  localparam int FL  = (C_HZOE > C_HZCE) ? C_HZOE : C_HZCE;
  localparam int SDM = (C_SD > 1) ? C_SD : 1;
  localparam int W0  = (C_PWE > C_AW) ? C_PWE : C_AW;
  localparam int W1  = (W0 > C_HZWE + SDM) ? W0 : C_HZWE + SDM;
  localparam int W2  = (W1 > C_WC - 1) ? W1 : C_WC - 1;
  localparam int W   = (W2 > 1) ? W2 : 1;
  localparam int HD  = C_HD;
  localparam int DRV_FROM = W - C_HZWE;
  localparam int M0  = (RD > W) ? RD : W;
  localparam int M1  = (FL > HD) ? FL : HD;
  localparam int MAXC = (M0 > M1) ? M0 : M1;
  localparam int CW  = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_TURN} st_e;

  st_e               st;
  logic [CW-1:0]     cnt;
  logic              wr_q;
  logic              live;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      live     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      live     <= 1'b1;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
            if (req_write) begin
              st  <= S_SETUP;
              cnt <= '0;
            end else begin
              st  <= S_STROBE;
              cnt <= CW'(RD - 1);
            end
          end
        S_SETUP: begin
          st  <= S_STROBE;
          cnt <= CW'(W - 1);
        end
        S_STROBE:
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (wr_q) begin
            if (HD > 0) begin
              st  <= S_HOLD;
              cnt <= CW'(HD - 1);
            end else begin
              st <= S_IDLE;
            end
          end else begin
            rd_data  <= sram_dq_in;
            rd_valid <= 1'b1;
            if (FL > 0) begin
              st  <= S_TURN;
              cnt <= CW'(FL - 1);
            end else begin
              st <= S_IDLE;
            end
          end
        S_HOLD, S_TURN:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel         = (st == S_SETUP) || (st == S_STROBE);
  assign ready       = (st == S_IDLE);
  assign sram_cs_n   = !sel;
  assign sram_cs     = sel;
  assign sram_we_n   = !((st == S_STROBE) && wr_q);
  assign sram_oe_n   = WE_ONLY ? !live : !((st == S_STROBE) && !wr_q);
  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign sram_dq_oe  = wr_q && (((st == S_STROBE) && (int'(cnt) < DRV_FROM)) || (st == S_HOLD));

endmodule

module sram_ctrl_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter bit WE_ONLY = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ready,
  input logic              rd_valid,
  input logic              sram_cs_n,
  input logic              sram_cs,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  a_r2_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs_n == !sram_cs);

  a_r5_we_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_cs));

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (!sram_we_n || sram_cs_n));

  a_r7_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ready) |=> !ready);

  a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !WE_ONLY |-> !(!sram_oe_n && !sram_we_n));

  a_r9_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (WE_ONLY && !$past(sram_oe_n)) |-> !sram_oe_n);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WE_ONLY(WE_ONLY)) u_chk (.*);

// File: tb/sram_ctrl_tb.sv
module sram_model #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int AA_C = 2, parameter int ACE_C = 2,
  parameter int HZWE_C = 1, parameter int FL_C = 1,
  parameter int PWE_C = 2, parameter int SD_C = 1, parameter int AW_C = 2
) (
  input  logic              clk,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              din_oe,
  output logic [DATA_W-1:0] dout,
  output int                n_chk,
  output int                n_bad
);
  logic [DATA_W-1:0] mem [2**ADDR_W];
  int sel_cnt = 0, addr_cnt = 0, we_cnt = 0, sd_cnt = 0, tail = 0, last_acnt = 0;
  logic prev_rd = 0, prev_wl = 0, drv = 0;
  logic [ADDR_W-1:0] prev_addr = '0, last_addr = '0;
  logic [DATA_W-1:0] last_d = '0;

  initial begin
    n_chk = 0; n_bad = 0; dout = '0;
    for (int i = 0; i < 2**ADDR_W; i++) mem[i] = '0;
  end

  always @(negedge clk) begin
    logic sel, rdc, wl;
    sel = !cs_n && cs;
    rdc = sel && !oe_n && we_n;
    wl  = sel && !we_n;
    sel_cnt  = sel ? sel_cnt + 1 : 0;
    addr_cnt = (addr == prev_addr) ? addr_cnt + 1 : 1;
    prev_addr = addr;
    if (rdc) begin
      drv = 1; tail = 0;
    end else begin
      if (prev_rd) tail = wl ? HZWE_C : FL_C;
      drv = (tail > 0);
      if (tail > 0) tail = tail - 1;
    end
    prev_rd = rdc;
    if (din_oe && drv) begin
      n_bad++;
      $display("FAIL R6: bus contention at %0t got driver=1 exp driver=0", $time);
    end
    if (wl) begin
      we_cnt++;
      if (din_oe) begin
        sd_cnt = (sd_cnt > 0 && din == last_d) ? sd_cnt + 1 : 1;
        last_d = din;
      end else sd_cnt = 0;
      last_addr = addr;
      last_acnt = addr_cnt;
    end else if (prev_wl) begin
      n_chk++;
      if (we_cnt < PWE_C || sd_cnt < SD_C || last_acnt < AW_C) begin
        n_bad++;
        $display("FAIL R7: write timing got we=%0d sd=%0d aw=%0d exp >= %0d/%0d/%0d",
                 we_cnt, sd_cnt, last_acnt, PWE_C, SD_C, AW_C);
      end
      mem[last_addr] = last_d;
      we_cnt = 0; sd_cnt = 0;
    end
    prev_wl = wl;
    dout = (rdc && sel_cnt >= ACE_C && addr_cnt >= AA_C) ? mem[addr] : ~mem[addr];
  end
endmodule

module sram_ctrl_tb;
  localparam int AW = 4, DW = 8, CLK = 10;
  function automatic int cyc(input int ns); return (ns + CLK - 1) / CLK; endfunction
  function automatic int mx(input int a, input int b); return a > b ? a : b; endfunction
  localparam int RD   = mx(mx(cyc(20), cyc(20)), 1);
  localparam int FL   = mx(cyc(8), cyc(10));
  localparam int HZWE = cyc(10);
  localparam int HD   = cyc(0);
  localparam int W    = mx(mx(mx(mx(cyc(13), cyc(15)), HZWE + mx(cyc(10), 1)), cyc(20) - 1), 1);

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;

  logic rdy[2], rdv[2], csn[2], cs[2], oen[2], wen[2], dqoe[2];
  logic [DW-1:0] rdd[2], dqo[2], dqi[2];
  logic [AW-1:0] sa[2];
  int mchk[2], mbad[2];

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .WE_ONLY(1'b0)) u_dut (
    .clk, .rst_n, .req, .req_write, .req_addr, .req_wdata,
    .ready(rdy[0]), .rd_valid(rdv[0]), .rd_data(rdd[0]), .sram_cs_n(csn[0]), .sram_cs(cs[0]),
    .sram_oe_n(oen[0]), .sram_we_n(wen[0]), .sram_addr(sa[0]), .sram_dq_out(dqo[0]),
    .sram_dq_oe(dqoe[0]), .sram_dq_in(dqi[0]));
  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK), .WE_ONLY(1'b1)) u_dut_weo (
    .clk, .rst_n, .req, .req_write, .req_addr, .req_wdata,
    .ready(rdy[1]), .rd_valid(rdv[1]), .rd_data(rdd[1]), .sram_cs_n(csn[1]), .sram_cs(cs[1]),
    .sram_oe_n(oen[1]), .sram_we_n(wen[1]), .sram_addr(sa[1]), .sram_dq_out(dqo[1]),
    .sram_dq_oe(dqoe[1]), .sram_dq_in(dqi[1]));

  for (genvar g = 0; g < 2; g++) begin : g_mem
    sram_model #(.ADDR_W(AW), .DATA_W(DW), .AA_C(cyc(20)), .ACE_C(cyc(20)), .HZWE_C(HZWE),
                 .FL_C(FL), .PWE_C(cyc(13)), .SD_C(cyc(10)), .AW_C(cyc(15))) u_mem (
      .clk, .cs_n(csn[g]), .cs(cs[g]), .oe_n(oen[g]), .we_n(wen[g]), .addr(sa[g]),
      .din(dqo[g]), .din_oe(dqoe[g]), .dout(dqi[g]), .n_chk(mchk[g]), .n_bad(mbad[g]));
  end

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] shadow [2**AW];

  task automatic chk(input bit ok, input string rq, input string what, input int got, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s got %0d exp %0d", rq, what, got, exp);
    end
  endtask

  task automatic report();
    n_cmp += mchk[0] + mchk[1] + 2;
    n_bad += mbad[0] + mbad[1];
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic do_op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int k, lat[2], wel[2], drv[2], oel[2], sel[2], pair_bad;
    logic [DW-1:0] got[2];
    @(negedge clk);
    while (!rdy[0]) @(negedge clk);
    req = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    k = 1; pair_bad = 0;
    for (int i = 0; i < 2; i++) begin lat[i] = 0; wel[i] = 0; drv[i] = 0; oel[i] = 0; sel[i] = 0; got[i] = '0; end
    forever begin
      if (poke && k == 2) begin req = 1; req_write = 1; req_addr = a ^ 1; req_wdata = ~d; end
      if (poke && k == 3) req = 0;
      for (int i = 0; i < 2; i++) begin
        if (csn[i] != !cs[i]) pair_bad++;
        if (!csn[i]) sel[i]++;
        if (!wen[i]) wel[i]++;
        if (dqoe[i]) drv[i]++;
        if (!oen[i]) oel[i]++;
        if (rdv[i]) begin lat[i] = k; got[i] = rdd[i]; end
      end
      if (rdy[0] != rdy[1]) pair_bad++;
      if (rdy[0]) break;
      @(negedge clk);
      k++;
    end
    chk(pair_bad == 0, "R2", "enable pair / mode ready mismatches", pair_bad, 0);
    if (w) begin
      chk(k == W + HD + 2, "R5", "write busy length", k, W + HD + 2);
      chk(wel[0] == W && wel[1] == W, "R5", "we low cycles", wel[0], W);
      chk(drv[0] == W - HZWE + HD && drv[1] == W - HZWE + HD, "R6", "driver cycles", drv[1], W - HZWE + HD);
      chk(sel[0] == 1 + W, "R2", "write select cycles", sel[0], 1 + W);
      chk(oel[0] == 0, "R9", "normal mode oe low during write", oel[0], 0);
      chk(oel[1] == k, "R9", "we-only oe low cycles during write", oel[1], k);
      shadow[a] = d;
    end else begin
      chk(k == RD + FL + 1, "R4", "read busy length", k, RD + FL + 1);
      chk(lat[0] == RD + 1 && lat[1] == RD + 1, "R3", "read valid cycle", lat[0], RD + 1);
      chk(got[0] == shadow[a], "R10", "read data normal mode", got[0], shadow[a]);
      chk(got[1] == shadow[a], "R10", "read data we-only mode", got[1], shadow[a]);
      chk(sel[0] == RD, "R2", "read select cycles", sel[0], RD);
      chk(oel[0] == RD, "R9", "normal mode oe low cycles", oel[0], RD);
      chk(drv[0] == 0 && drv[1] == 0, "R6", "driver on during read", drv[0] + drv[1], 0);
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung got timeout exp completion");
    report();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 2**AW; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(csn[i] == 1 && cs[i] == 0, "R1", "reset chip enables", {csn[i], cs[i]}, 2);
      chk(oen[i] == 1 && wen[i] == 1, "R1", "reset oe/we", {oen[i], wen[i]}, 3);
      chk(dqoe[i] == 0 && rdy[i] == 1 && rdv[i] == 0, "R1", "reset driver/ready/valid",
          {dqoe[i], rdy[i], rdv[i]}, 2);
    end
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk(oen[1] == 0, "R9", "we-only oe after reset", oen[1], 0);
    chk(oen[0] == 1, "R9", "normal oe idle", oen[0], 1);
    do_op(0, 4'h3, 8'h00, 0);
    do_op(1, 4'h0, 8'hFF, 0);
    do_op(1, 4'hF, 8'hA5, 0);
    do_op(0, 4'h0, 8'h00, 0);
    do_op(0, 4'hF, 8'h00, 0);
    do_op(1, 4'hF, 8'h5A, 0);
    do_op(0, 4'hF, 8'h00, 0);
    do_op(1, 4'h6, 8'h3C, 1);
    do_op(0, 4'h7, 8'h00, 0);
    do_op(0, 4'h6, 8'h00, 1);
    do_op(0, 4'h7, 8'h00, 0);
    for (int n = 0; n < 400; n++)
      do_op($urandom_range(0, 1), AW'($urandom_range(0, 2**AW - 1)), DW'($urandom), 0);
    for (int i = 0; i < 2**AW; i++) do_op(0, AW'(i), 8'h00, 0);
    repeat (4) @(negedge clk);
    report();
  end
endmodule